// File: doc/BRIEF.md
# Program/Erase Busy Status Reporter

This block models the busy phase that follows the final write of an embedded program or erase command, together with the status bits that a host polls while that phase runs. A qualified write strobe starts the operation. The strobe must be a write-enable low pulse of at least a minimum width, issued after the power-on inhibit interval has ended and while no operation is running. When the operation starts, the block captures the operation type and the written word. It then counts a busy interval of a set length: one length for program and a longer one for erase.

While the block is busy and reads are asynchronous, read data from the array is replaced by status. Bit 7 gives the data-polling value and bit 6 gives a toggle bit that changes on every new read access. When the count expires, the block pulses a completion flag and returns plain array data with no host action. The real program and erase times are shortened to clock-cycle counts set by parameters. Supply sensing is reduced to a single power-good input.

Top module: `pe_status_top`

## Requirements
- R1: Out of reset, busy_o and done_o are 0, wr_inhibit_o is 1 and rd_data_o is 0.
- R2: wr_inhibit_o stays high while pwr_good_i is low. It falls after pwr_good_i has been high for POR_CYC clock edges. A write pulse issued while wr_inhibit_o is high never raises busy_o.
- R3: A write starts only on the rising edge of we_n_i that ends a low pulse of at least MIN_WE_CYC sampled cycles. A shorter pulse leaves busy_o low.
- R4: busy_o goes high on the clock edge that accepts the write. It stays high for exactly PROG_CYC cycles when op_erase_i was 0 at that edge, and for exactly ERASE_CYC cycles when op_erase_i was 1.
- R5: done_o is high for exactly one cycle, the first cycle after busy_o falls. After that, reads return array_data_i unchanged.
- R6: During a program, in asynchronous mode (async_mode_i = 1), rd_data_o[7] is the inverse of bit 7 of the written word. All other bits except bit 6 come from array_data_i.
- R7: During an erase, in asynchronous mode, rd_data_o[7] reads 0.
- R8: A new read access starts when ce_n_i and oe_n_i are both low and were not both low in the previous cycle. While busy in asynchronous mode, rd_data_o[6] shows a toggle bit. That bit is cleared when an operation starts and inverts at each new read access, so the first read after start shows 1.
- R9: With async_mode_i = 0, rd_data_o equals array_data_i during a read even while busy.
- R10: A write pulse during busy is ignored. The busy interval keeps its original length and operation type.
- R11: When ce_n_i or oe_n_i is high, rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply above write threshold |
| we_n_i | input | 1 | Write enable, active low |
| op_erase_i | input | 1 | Operation type of the write: 1 erase, 0 program |
| wr_data_i | input | 16 | Word written by the host |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| async_mode_i | input | 1 | 1 selects asynchronous reads |
| array_data_i | input | 16 | Normal array read data |
| rd_data_o | output | 16 | Read data with status substitution |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_inhibit_o | output | 1 | Power-on write inhibit active |

## Verification
Some properties are checked by assertions on every cycle. A write is never accepted while inhibited or busy. The busy interval is armed and released correctly, and done_o follows every fall of busy_o. The erase polling bit is 0 while busy. Idle reads pass array data, and reads outside an access return zero. The toggle bit inverts on each new access while busy.

Other behaviour needs the bench's scenarios: the exact busy lengths for each operation type, the power-on delay count, rejection of short write pulses, and the read-by-read alternation of bit 6 over random data and operations.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
endpackage

// File: rtl/pe_por_inhibit.sv
module pe_por_inhibit #(
  parameter int unsigned POR_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic inhibit_o
);
  localparam int unsigned CW = $clog2(POR_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!pwr_good_i)                cnt_q <= '0;
    else if (cnt_q != CW'(POR_CYC))      cnt_q <= cnt_q + 1'b1;
  end

  assign inhibit_o = !pwr_good_i || (cnt_q != CW'(POR_CYC));

  assert_inhibit_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> inhibit_o);
endmodule

// File: rtl/pe_we_filter.sv
module pe_we_filter #(
  parameter int unsigned MIN_WE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_n_i,
  output logic accept_o
);
  localparam int unsigned CW = $clog2(MIN_WE_CYC + 1);
  logic [CW-1:0] wcnt_q;
  logic          we_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      we_n_q <= 1'b1;
    end else begin
      we_n_q <= we_n_i;
      if (we_n_i)                              wcnt_q <= '0;
      else if (wcnt_q != CW'(MIN_WE_CYC))      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  // rising edge of we_n after a long-enough low pulse
  assign accept_o = we_n_i && !we_n_q && (wcnt_q == CW'(MIN_WE_CYC));

  assert_accept_after_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !$past(we_n_i));
endmodule

// File: rtl/pe_busy_timer.sv
module pe_busy_timer
  import pe_status_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned PROG_CYC  = 20,
  parameter int unsigned ERASE_CYC = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  op_e           op_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output op_e           op_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
      op_o   <= OP_PROG;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        op_o   <= op_i;
        data_o <= data_i;
        cnt_q  <= (op_i == OP_ERASE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
      end else if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assert_start_sets_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_op_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(op_o));
endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux
  import pe_status_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          busy_i,
  input  op_e           op_i,
  input  logic          wr_bit7_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          async_mode_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic rd_act, rd_q, tgl_q, rd_start;

  assign rd_act   = !ce_n_i && !oe_n_i;
  assign rd_start = rd_act && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (start_i)                 tgl_q <= 1'b0;
      else if (busy_i && rd_start) tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_act) begin
      rd_data_o = array_data_i;
      if (busy_i && async_mode_i) begin
        rd_data_o[7] = (op_i == OP_PROG) ? ~wr_bit7_i : 1'b0;
        rd_data_o[6] = tgl_q;
      end
    end
  end

  assert_erase_poll_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && busy_i && async_mode_i && op_i == OP_ERASE) |-> !rd_data_o[7]);
  assert_idle_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && !busy_i) |-> rd_data_o == array_data_i);
  assert_no_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_act |-> rd_data_o == '0);
  assert_toggle_flips_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_start && !start_i) |=> tgl_q != $past(tgl_q));
endmodule

// File: rtl/pe_status_top.sv
module pe_status_top
  import pe_status_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned PROG_CYC   = 20,
  parameter int unsigned ERASE_CYC  = 40,
  parameter int unsigned POR_CYC    = 16,
  parameter int unsigned MIN_WE_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_good_i,
  input  logic          we_n_i,
  input  logic          op_erase_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          async_mode_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          wr_inhibit_o
);
  logic          accept, start;
  op_e           op_in, op_cur;
  logic [DW-1:0] data_cur;

  assign op_in = op_erase_i ? OP_ERASE : OP_PROG;

  pe_por_inhibit #(.POR_CYC(POR_CYC)) u_por (
    .clk_i, .rst_ni, .pwr_good_i, .inhibit_o(wr_inhibit_o)
  );

  pe_we_filter #(.MIN_WE_CYC(MIN_WE_CYC)) u_wef (
    .clk_i, .rst_ni, .we_n_i, .accept_o(accept)
  );

  assign start = accept && !wr_inhibit_o && !busy_o;

  pe_busy_timer #(.DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .op_i(op_in), .data_i(wr_data_i),
    .busy_o, .done_o, .op_o(op_cur), .data_o(data_cur)
  );

  pe_status_mux #(.DW(DW)) u_mux (
    .clk_i, .rst_ni, .start_i(start), .busy_i(busy_o), .op_i(op_cur),
    .wr_bit7_i(data_cur[7]), .ce_n_i, .oe_n_i, .async_mode_i, .array_data_i,
    .rd_data_o
  );

  assert_no_start_inhibited_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inhibit_o |=> !$rose(busy_o));
  assert_no_restart_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy_o);
endmodule

// File: tb/tb_pe_status_top.sv
module tb_pe_status_top;
  localparam int DW = 16, PROG = 20, ERASE = 40, POR = 16, MINW = 3;

  logic clk = 0, rst_n = 0, pwr = 0, we_n = 1, op_e = 0, ce_n = 1, oe_n = 1, am = 1;
  logic [DW-1:0] wd = '0, arr = '0, rd;
  logic busy, done, inh;
  int checks = 0, fails = 0, cyc = 0;
  logic exp_tgl;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pe_status_top #(.DW(DW), .PROG_CYC(PROG), .ERASE_CYC(ERASE), .POR_CYC(POR),
                  .MIN_WE_CYC(MINW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .we_n_i(we_n), .op_erase_i(op_e),
    .wr_data_i(wd), .ce_n_i(ce_n), .oe_n_i(oe_n), .async_mode_i(am),
    .array_data_i(arr), .rd_data_o(rd), .busy_o(busy), .done_o(done), .wr_inhibit_o(inh));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic bsy, input logic er,
      input logic [DW-1:0] w, input logic [DW-1:0] a, input logic t, input logic asy);
    logic [DW-1:0] r = a;
    if (bsy && asy) begin
      r[7] = er ? 1'b0 : ~w[7];
      r[6] = t;
    end
    return r;
  endfunction

  task automatic wr_pulse(input logic er, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    op_e = er; wd = d; we_n = 0;
    repeat (len) @(negedge clk);
    we_n = 1;
    @(negedge clk);
  endtask

  // read while tracking the toggle model; returns sampled data
  task automatic do_read(input logic [DW-1:0] a, output logic [DW-1:0] r, output logic b);
    ce_n = 0; oe_n = 0; arr = a;
    b = busy;
    if (b) exp_tgl = ~exp_tgl;
    @(negedge clk);
    r = rd;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int fell_cyc);
    int g = 0;
    while (busy && g < 1000) begin @(negedge clk); g++; end
    fell_cyc = cyc;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] r, w, a;
    logic b, er;
    int t0, t1, n;
    void'($urandom(32'h1a2b3c));
    #1;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 inhibit", inh, 1); chk("R1 rd", rd, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    // write while power not good: inhibited
    wr_pulse(0, 16'h00ff, MINW);
    chk("R2 no start while inhibited", busy, 0);
    @(negedge clk); pwr = 1;
    n = 0;
    @(negedge clk);
    while (inh && n < 100) begin n++; @(negedge clk); end
    chk("R2 por delay", n, POR - 1);
    pwr = 0; #1; chk("R2 reinhibit", inh, 1);
    @(negedge clk); pwr = 1;
    repeat (POR + 1) @(negedge clk);
    chk("R2 released", inh, 0);
    // R11 idle read outputs
    arr = 16'hbeef; #1; chk("R11 no read", rd, 0);
    // glitch
    wr_pulse(0, 16'h1234, MINW - 1);
    chk("R3 short pulse rejected", busy, 0);
    repeat (2) @(negedge clk);
    chk("R3 still idle", busy, 0);
    // program duration + done
    wr_pulse(0, 16'h0080, MINW);
    t0 = cyc; chk("R3 min pulse accepted", busy, 1);
    wait_idle(t1);
    chk("R4 program length", t1 - t0, PROG);
    chk("R5 done pulse", done, 1);
    @(negedge clk); chk("R5 done single", done, 0);
    // erase duration with write during busy
    wr_pulse(1, 16'h0000, MINW);
    t0 = cyc; exp_tgl = 0;
    wr_pulse(0, 16'h0080, MINW + 1);
    do_read(16'hffff, r, b);
    chk("R10 op kept erase R7", r, exp_read(b, 1, 16'h0000, 16'hffff, exp_tgl, 1));
    wait_idle(t1);
    chk("R10 R4 erase length", t1 - t0, ERASE);
    do_read(16'h5aa5, r, b);
    chk("R5 normal read after", r, 16'h5aa5);
    // sync mode during busy
    wr_pulse(0, 16'h0000, MINW);
    am = 0;
    do_read(16'h0f0f, r, b);
    chk("R9 sync passthru", r, 16'h0f0f);
    am = 1;
    wait_idle(t1);
    // random program/erase with polled reads
    for (int k = 0; k < 20; k++) begin
      er = $urandom_range(0, 1);
      w = $urandom;
      wr_pulse(er, w, MINW + $urandom_range(0, 2));
      exp_tgl = 0;
      for (int j = 0; j < 4; j++) begin
        a = $urandom;
        do_read(a, r, b);
        chk(er ? "R7 R8 erase poll" : "R6 R8 program poll", r,
            exp_read(b, er, w, a, exp_tgl, 1));
      end
      wait_idle(t1);
      a = $urandom;
      do_read(a, r, b);
      chk("R5 after done", r, a);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule